// File: doc/BRIEF.md
# Expanded-Bus Memory Map Decoder

This block sits beside an 8-bit processor whose external bus is run in expanded form. Each cycle the high address byte arrives on a dedicated port. The low byte shares a time-multiplexed port with data. An address strobe marks the part of the cycle in which that shared port holds the low byte. The block keeps a copy of the low byte that stays valid after the strobe falls. It also decodes the high address byte into active-low chip enables for four 1K RAM banks, four 4K ROM banks, one ROM output enable and one I/O page select.

All enables are qualified by the bus E phase. They are registered on the block clock, so every enable is glitch-free and appears one clock after the inputs it reflects. The parameter `FULL_RAM_DECODE` sets how the RAM region is decoded. When it is 1, the four upper address bits must all be zero. When it is 0, only the top address bit is checked, and the 4K RAM image repeats through the lower half of the map.

The block has no data path of its own, so there is no streaming interface and no back-pressure. All pins are plain level signals.

Top module: `memmap_decoder`

## Requirements
- R1: `lo_addr` takes the value of `mux_bus` at each rising `clk` edge on which `addr_strobe` is 1. It keeps its value at edges on which `addr_strobe` is 0.
- R2: RAM occupies page bytes $00–$0F. Bank index k = address bits 11:10 (page bits 3:2) drives `ram_cs_n[k]` low.
- R3: With `FULL_RAM_DECODE`=1, a RAM enable requires address bits 15:12 to be zero. $1000–$7FFF then selects nothing.
- R4: With `FULL_RAM_DECODE`=0, only address bit 15 must be zero. $0000–$7FFF selects RAM bank bits 11:10, so the region mirrors every 4K.
- R5: ROM occupies $C000–$FFFF. Bank index k = address bits 13:12 drives `rom_ce_n[k]` low.
- R6: `io_cs_n` is low for every address $8000–$8FFF.
- R7: Every enable output is high unless `e_phase` was 1 at the sampling edge. Each output reflects the inputs at the previous rising `clk` edge.
- R8: `rom_oe_n` goes low only together with a ROM bank enable and only when `rd_wr_n` is 1 (read). A ROM-space write enables the bank but leaves `rom_oe_n` high.
- R9: Addresses $9000–$BFFF assert no enable.
- R10: At most one of the RAM, ROM and I/O enables is low at any time.
- R11: While `rst_n` is 0, all enables are high and `lo_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_bus | input | 8 | Shared low-address/data port |
| addr_strobe | input | 1 | High while `mux_bus` carries the low address byte |
| page_addr | input | 8 | Address bits 15:8 |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| e_phase | input | 1 | Bus E phase; enables are allowed only while high |
| lo_addr | output | 8 | Captured low address byte |
| ram_cs_n | output | 4 | RAM bank enables, active low |
| rom_ce_n | output | 4 | ROM bank enables, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| io_cs_n | output | 1 | I/O page select, active low |

## Verification
Any fault in the decoded region or bank index shows up one clock later as the wrong enable, or as two enables low together. This is why every page value is swept under both decode settings, with reads, writes and E low. A wrong capture register shows on `lo_addr` at the first edge after the strobe falls, when a changed `mux_bus` value must not pass through. A missing E qualification is caught at the first vector that has E low.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int PAGE_W     = 8;
  localparam int RAM_BANKS  = 4;
  localparam int ROM_BANKS  = 4;
  localparam int RAM_BANK_W = $clog2(RAM_BANKS);
  localparam int ROM_BANK_W = $clog2(ROM_BANKS);

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RAM  = 2'd1,
    REG_ROM  = 2'd2,
    REG_IO   = 2'd3
  } region_e;
endpackage

// File: rtl/addr_lo_capture.sv
module addr_lo_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] lo_out
);
  always_ff @(posedge clk) begin
    if (!rst_n)      lo_out <= '0;
    else if (strobe) lo_out <= bus_in;
  end

  // R1: follow the shared port while strobed, hold otherwise
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> lo_out == $past(bus_in));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(lo_out));
endmodule

// File: rtl/region_decode.sv
module region_decode
  import memmap_pkg::*;
#(
  parameter bit FULL_RAM_DECODE = 1'b1
) (
  input  logic [7:2]            blk,       // address bits 15:10
  output region_e               region,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic [ROM_BANK_W-1:0] rom_bank
);
  logic ram_hit;

  generate
    if (FULL_RAM_DECODE) begin : g_full
      assign ram_hit = (blk[7:4] == 4'h0);
    end else begin : g_part
      assign ram_hit = !blk[7];
    end
  endgenerate

  assign ram_bank = blk[2 +: RAM_BANK_W];
  assign rom_bank = blk[4 +: ROM_BANK_W];

  always_comb begin
    if (ram_hit)                  region = REG_RAM;
    else if (blk[7:6] == 2'b11)   region = REG_ROM;
    else if (blk[7:4] == 4'h8)    region = REG_IO;
    else                          region = REG_NONE;
  end
endmodule

// File: rtl/select_reg.sv
module select_reg
  import memmap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  region_e               region,
  input  logic [RAM_BANK_W-1:0] ram_bank,
  input  logic [ROM_BANK_W-1:0] rom_bank,
  input  logic                  rd_wr_n,
  input  logic                  e_phase,
  output logic [RAM_BANKS-1:0]  ram_cs_n,
  output logic [ROM_BANKS-1:0]  rom_ce_n,
  output logic                  rom_oe_n,
  output logic                  io_cs_n
);
  logic [RAM_BANKS-1:0] ram_nx;
  logic [ROM_BANKS-1:0] rom_nx;

  for (genvar gi = 0; gi < RAM_BANKS; gi++) begin : g_ram
    assign ram_nx[gi] = e_phase && (region == REG_RAM) && (ram_bank == RAM_BANK_W'(gi));
  end
  for (genvar gj = 0; gj < ROM_BANKS; gj++) begin : g_rom
    assign rom_nx[gj] = e_phase && (region == REG_ROM) && (rom_bank == ROM_BANK_W'(gj));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_cs_n <= '1;
      rom_ce_n <= '1;
      rom_oe_n <= 1'b1;
      io_cs_n  <= 1'b1;
    end else begin
      ram_cs_n <= ~ram_nx;
      rom_ce_n <= ~rom_nx;
      rom_oe_n <= !(e_phase && (region == REG_ROM) && rd_wr_n);
      io_cs_n  <= !(e_phase && (region == REG_IO));
    end
  end

  // R7: nothing enabled after an edge with E low
  p_e_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !e_phase |=> (&ram_cs_n && &rom_ce_n && rom_oe_n && io_cs_n));
  // R8: output enable only on reads, only with a ROM bank
  p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_wr_n |=> rom_oe_n);
  p_oe_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> $countones(~rom_ce_n) == 1);
  // R10: a single device at a time
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ram_cs_n, ~rom_ce_n, ~io_cs_n}));
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter bit FULL_RAM_DECODE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PAGE_W-1:0]    mux_bus,
  input  logic                 addr_strobe,
  input  logic [PAGE_W-1:0]    page_addr,
  input  logic                 rd_wr_n,
  input  logic                 e_phase,
  output logic [PAGE_W-1:0]    lo_addr,
  output logic [RAM_BANKS-1:0] ram_cs_n,
  output logic [ROM_BANKS-1:0] rom_ce_n,
  output logic                 rom_oe_n,
  output logic                 io_cs_n
);
  region_e               region;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic [ROM_BANK_W-1:0] rom_bank;

  addr_lo_capture #(.W(PAGE_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .strobe(addr_strobe),
    .bus_in(mux_bus), .lo_out(lo_addr)
  );

  region_decode #(.FULL_RAM_DECODE(FULL_RAM_DECODE)) u_dec (
    .blk(page_addr[7:2]), .region(region),
    .ram_bank(ram_bank), .rom_bank(rom_bank)
  );

  select_reg u_sel (
    .clk(clk), .rst_n(rst_n), .region(region), .ram_bank(ram_bank),
    .rom_bank(rom_bank), .rd_wr_n(rd_wr_n), .e_phase(e_phase),
    .ram_cs_n(ram_cs_n), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .io_cs_n(io_cs_n)
  );

  // R9: gap between I/O page and ROM stays silent
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (page_addr[7:6] == 2'b10 && page_addr[5:4] != 2'b00)
      |=> (&ram_cs_n && &rom_ce_n && io_cs_n));
  // R6: I/O page with E high selects I/O
  p_io_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (e_phase && page_addr[7:4] == 4'h8) |=> !io_cs_n);

  generate
    if (FULL_RAM_DECODE) begin : g_chk_full
      // R3: no RAM image above the first 4K
      p_no_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (page_addr[7:4] != 4'h0) |=> &ram_cs_n);
    end else begin : g_chk_part
      // R4: the lower half always hits a RAM bank when E is high
      p_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_phase && !page_addr[7]) |=> !(&ram_cs_n));
    end
  endgenerate
endmodule

// File: tb/memmap_decoder_tb.sv
module memmap_decoder_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mux_bus = 8'h00;
  logic       addr_strobe = 1'b0;
  logic [7:0] page_addr = 8'h00;
  logic       rd_wr_n = 1'b1;
  logic       e_phase = 1'b0;

  logic [7:0] lo_f, lo_p;
  logic [3:0] ram_f, rom_f, ram_p, rom_p;
  logic       oe_f, io_f, oe_p, io_p;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [7:0] hi;
    logic       rd;
    logic       en;
  } item_t;
  item_t q[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  memmap_decoder #(.FULL_RAM_DECODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .mux_bus(mux_bus), .addr_strobe(addr_strobe),
    .page_addr(page_addr), .rd_wr_n(rd_wr_n), .e_phase(e_phase),
    .lo_addr(lo_f), .ram_cs_n(ram_f), .rom_ce_n(rom_f), .rom_oe_n(oe_f), .io_cs_n(io_f)
  );
  memmap_decoder #(.FULL_RAM_DECODE(1'b0)) u_dut_part (
    .clk(clk), .rst_n(rst_n), .mux_bus(mux_bus), .addr_strobe(addr_strobe),
    .page_addr(page_addr), .rd_wr_n(rd_wr_n), .e_phase(e_phase),
    .lo_addr(lo_p), .ram_cs_n(ram_p), .rom_ce_n(rom_p), .rom_oe_n(oe_p), .io_cs_n(io_p)
  );

  // Packing: {io, rom_oe, rom[3:0], ram[3:0]}, all active low
  function automatic logic [9:0] model(input logic [7:0] hi, input logic rd,
                                       input logic en, input logic full);
    logic [9:0] r;
    r = '1;
    if (en) begin
      if (full ? (hi[7:4] == 4'h0) : !hi[7]) r[hi[3:2]] = 1'b0;      // R2 R3 R4
      else if (hi[7:6] == 2'b11) begin                                 // R5
        r[4 + hi[5:4]] = 1'b0;
        if (rd) r[8] = 1'b0;                                           // R8
      end else if (hi[7:4] == 4'h8) r[9] = 1'b0;                       // R6
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] hi, input logic rd,
                                   input logic en, input logic full);
    if (!en)                      return "R7";
    if (full && hi[7:4] == 4'h0)  return "R2";
    if (full && !hi[7])           return "R3";
    if (!full && !hi[7])          return "R4";
    if (hi[7:6] == 2'b11)         return rd ? "R5" : "R8";
    if (hi[7:4] == 4'h8)          return "R6";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] hi, input logic rd, input logic en);
    item_t it;
    @(negedge clk);
    page_addr = hi;
    rd_wr_n   = rd;
    e_phase   = en;
    it.due = cyc + 1;
    it.hi  = hi;
    it.rd  = rd;
    it.en  = en;
    q.push_back(it);
  endtask

  // monitor: compare once the registered enables have had their edge
  always @(negedge clk) begin
    if (q.size() != 0 && q[0].due <= cyc) begin
      item_t it;
      logic [9:0] af, ap;
      it = q.pop_front();
      af = {io_f, oe_f, rom_f, ram_f};
      ap = {io_p, oe_p, rom_p, ram_p};
      check(tag_of(it.hi, it.rd, it.en, 1'b1), 32'(af), 32'(model(it.hi, it.rd, it.en, 1'b1)));
      check(tag_of(it.hi, it.rd, it.en, 1'b0), 32'(ap), 32'(model(it.hi, it.rd, it.en, 1'b0)));
      // R10: at most one device selected
      check("R10", 32'($countones({~ram_f, ~rom_f, ~io_f}) <= 1), 32'd1);
      check("R10", 32'($countones({~ram_p, ~rom_p, ~io_p}) <= 1), 32'd1);
    end
  end

  initial begin
    #(CLK_P * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11: reset state, driven with E high and a RAM address present
    page_addr = 8'h00; e_phase = 1'b1; addr_strobe = 1'b1; mux_bus = 8'hC3;
    repeat (3) @(negedge clk);
    check("R11", 32'({io_f, oe_f, rom_f, ram_f}), 32'h3FF);
    check("R11", 32'(lo_f), 32'h00);
    addr_strobe = 1'b0; e_phase = 1'b0;
    rst_n = 1'b1;

    // R1: capture while strobed, hold after strobe drops
    @(negedge clk); mux_bus = 8'h5A; addr_strobe = 1'b1;
    @(negedge clk); check("R1", 32'(lo_f), 32'h5A);
    addr_strobe = 1'b0; mux_bus = 8'hFF;
    @(negedge clk); check("R1", 32'(lo_f), 32'h5A);
    mux_bus = 8'h11;
    @(negedge clk); check("R1", 32'(lo_p), 32'h5A);
    addr_strobe = 1'b1; mux_bus = 8'hA7;
    @(negedge clk); check("R1", 32'(lo_f), 32'hA7);
    addr_strobe = 1'b0;

    // full sweep of pages, read/write, E high/low
    for (int h = 0; h < 256; h++)
      for (int r = 0; r < 2; r++)
        for (int e = 0; e < 2; e++)
          drive(8'(h), r[0], e[0]);

    // back-to-back bank changes without E dropping
    drive(8'h0C, 1'b1, 1'b1);
    drive(8'hF0, 1'b1, 1'b1);
    drive(8'h80, 1'b0, 1'b1);
    drive(8'h7C, 1'b1, 1'b1);
    drive(8'hB0, 1'b1, 1'b1);

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule